// File: doc/BRIEF.md
# Hardware-Sequenced Serial Flash Cycle Engine

This block runs complete serial flash operations on its own. Software first loads a flash address into the address register and, for a program operation, loads up to 64 bytes into the data buffer. It then writes the control register with an operation code, a byte count and a start bit. The engine drives chip select, serial clock and data out itself. It samples data in, moves read bytes into the buffer, waits out the device's internal busy time, and reports the outcome in a status register.

A program or erase is always preceded by a one-byte write-enable frame. After the command, the engine keeps reading the device status byte until the device reports that it is idle. A read or program whose bytes would run past a 256-byte page is refused before any serial activity. Software must split such requests. A sticky lock flag, once set, refuses every program and erase until reset.

Top module: `hwseq_flash_engine`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, and the done, error, access-error, busy and lock status flags all read 0.
- R2: Register word 1 is the control register: bit 0 is start, bits 2:1 are the operation and bits 13:8 are the byte count minus one. A read (operation 0) sends 0x03 and then address bits 23:0, most significant byte first and most significant bit first. It then captures count+1 bytes into the buffer. Byte i goes to buffer word i/4 (register word 16+i/4) at bits 8*(i%4)+7:8*(i%4).
- R3: A page program (operation 2) sends a 0x06 frame, raises chip select, and then sends 0x02, the address and count+1 buffer bytes in one frame. It then sends a 0x05 frame that reads status bytes until bit 0 of a byte is 0, and only then sets done.
- R4: A block erase (operation 3) sends a 0x06 frame, then 0xD8 with the address and no data, then the same 0x05 polling frame, and then sets done.
- R5: A read or program for which address bits 7:0 plus the count exceed 255 sets the error flag (status bit 1). It produces no chip-select activity and leaves done at 0. A request ending exactly at byte 255 of a page runs normally.
- R6: A start with operation code 1 sets the error flag and produces no frame.
- R7: Writing 1 to status bit 15 sets the lock flag, and only reset clears it. While the lock is set, a program or erase sets the access-error flag (status bit 2) and produces no frame, while reads still run.
- R8: Status bits 0 (done), 1 (error) and 2 (access error) are cleared by writing 1 and are unchanged by writing 0. If the engine sets a flag in the same clock as a write of 1 clears it, the flag reads 1.
- R9: Status bit 5 is high from the clock after an accepted start until completion. While it is high, writes to the control, address and data registers are ignored, including a second start.
- R10: Done rises on the clock after the final serial clock falling edge of the operation. Chip select rises on that same clock.
- R11: Register word 2 reads back all 32 written bits. Only bits 23:0 are sent as the flash address.
- R12: Status bits 4:3 report the erase-size code parameter, which defaults to 1. Bit 14 reports the descriptor-valid parameter, which defaults to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Word address: 0 status, 1 control, 2 address, 16-31 data buffer |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| spi_sck | output | 1 | Serial clock, mode 0 |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
Two things can land on the same clock: the engine raising done at the end of an operation, and a software write of ones that clears the status flags. The bench first leaves the error flag set by a refused request. It then counts serial clock falling edges during a short read and issues a write of 1 to done and error so that it lands exactly on the completion clock. After that write, error must read 0 and done must read 1.

// File: rtl/hwseq_pkg.sv
`timescale 1ns/1ps
package hwseq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_WREN, ST_GAP, ST_CMD, ST_ADR, ST_DAT, ST_PCMD, ST_PRD
    } seq_e;

    localparam logic [1:0] CT_READ  = 2'd0;
    localparam logic [1:0] CT_BAD   = 2'd1;
    localparam logic [1:0] CT_PROG  = 2'd2;
    localparam logic [1:0] CT_ERASE = 2'd3;

    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_PROG  = 8'h02;
    localparam logic [7:0] OP_ERASE = 8'hD8;
    localparam logic [7:0] OP_RDSR  = 8'h05;

    localparam int REG_STAT = 0;
    localparam int REG_CTRL = 1;
    localparam int REG_ADDR = 2;
endpackage

// File: rtl/hwseq_spi_byte.sv
`timescale 1ns/1ps
module hwseq_spi_byte #(
    parameter int DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx
);
    localparam int DIVW = $clog2(DIV + 1);

    typedef struct packed {
        logic            busy;
        logic [DIVW-1:0] div;
        logic [2:0]      bitn;
        logic            sck;
        logic [7:0]      sh;
        logic [7:0]      rx;
        logic            done;
    } sft_t;

    sft_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (!s_q.busy) begin
            if (start) begin
                s_d.busy = 1'b1;
                s_d.sh   = tx;
                s_d.bitn = '0;
                s_d.div  = '0;
                s_d.sck  = 1'b0;
            end
        end else if (s_q.div == DIVW'(DIV - 1)) begin
            s_d.div = '0;
            if (!s_q.sck) begin
                s_d.sck = 1'b1;
                s_d.rx  = {s_q.rx[6:0], miso};
            end else begin
                s_d.sck = 1'b0;
                s_d.sh  = {s_q.sh[6:0], 1'b0};
                if (s_q.bitn == 3'd7) begin
                    s_d.busy = 1'b0;
                    s_d.done = 1'b1;
                end else begin
                    s_d.bitn = s_q.bitn + 3'd1;
                end
            end
        end else begin
            s_d.div = s_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sck  = s_q.sck;
    assign mosi = s_q.sh[7];
    assign done = s_q.done;
    assign rx   = s_q.rx;
endmodule

// File: rtl/hwseq_req_check.sv
`timescale 1ns/1ps
module hwseq_req_check
    import hwseq_pkg::*;
#(
    parameter int CNTW   = 6,
    parameter int PAGE_W = 8
) (
    input  logic [1:0]        typ,
    input  logic [CNTW-1:0]   cnt,
    input  logic [PAGE_W-1:0] page_off,
    input  logic              locked,
    output logic              bad_cycle,
    output logic              bad_access
);
    logic [PAGE_W:0] span_end;
    logic            crosses;
    logic            modifies;

    always_comb begin
        span_end   = {1'b0, page_off} + (PAGE_W + 1)'(cnt);
        crosses    = span_end[PAGE_W] && (typ == CT_READ || typ == CT_PROG);
        modifies   = (typ == CT_PROG) || (typ == CT_ERASE);
        bad_cycle  = 1'b0;
        bad_access = 1'b0;
        if (typ == CT_BAD)            bad_cycle  = 1'b1;
        else if (locked && modifies)  bad_access = 1'b1;
        else if (crosses)             bad_cycle  = 1'b1;
    end
endmodule

// File: rtl/hwseq_databuf.sv
`timescale 1ns/1ps
module hwseq_databuf #(
    parameter int WORDS = 16,
    parameter int WIDX  = $clog2(WORDS),
    parameter int BIDX  = WIDX + 2
) (
    input  logic            clk,
    input  logic            host_we,
    input  logic [WIDX-1:0] host_idx,
    input  logic [31:0]     host_wdata,
    output logic [31:0]     host_rdata,
    input  logic            eng_we,
    input  logic [BIDX-1:0] eng_idx,
    input  logic [7:0]      eng_wdata,
    output logic [7:0]      eng_rdata
);
    logic [31:0] words [WORDS];

    always_ff @(posedge clk) begin
        if (host_we) words[host_idx] <= host_wdata;
        if (eng_we)  words[eng_idx[BIDX-1:2]][8*eng_idx[1:0] +: 8] <= eng_wdata;
    end

    assign host_rdata = words[host_idx];
    assign eng_rdata  = words[eng_idx[BIDX-1:2]][8*eng_idx[1:0] +: 8];
endmodule

// File: rtl/hwseq_flash_engine.sv
`timescale 1ns/1ps
module hwseq_flash_engine
    import hwseq_pkg::*;
#(
    parameter int         BUF_WORDS  = 16,
    parameter int         CLK_DIV    = 2,
    parameter int         GAP_CYC    = 4,
    parameter int         PAGE_W     = 8,
    parameter logic [1:0] ERASE_CODE = 2'd1,
    parameter logic       DESC_VALID = 1'b1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_we,
    input  logic [$clog2(BUF_WORDS):0]    reg_addr,
    input  logic [31:0]                   reg_wdata,
    output logic [31:0]                   reg_rdata,
    output logic                          spi_sck,
    output logic                          spi_cs_n,
    output logic                          spi_mosi,
    input  logic                          spi_miso
);
    localparam int WIDX = $clog2(BUF_WORDS);
    localparam int AW   = WIDX + 1;
    localparam int CNTW = WIDX + 2;
    localparam int GAPW = $clog2(GAP_CYC);

    typedef struct packed {
        seq_e            st;
        seq_e            nxt;
        logic [CNTW-1:0] idx;
        logic            launched;
        logic [1:0]      typ;
        logic [CNTW-1:0] cnt;
        logic [31:0]     addr;
        logic            cs_n;
        logic            done;
        logic            err;
        logic            ael;
        logic            lock;
        logic [GAPW-1:0] gap;
    } regs_t;

    regs_t r_d, r_q;

    logic       busy, start, bdone, bwe, fin, set_err, set_ael;
    logic       bad_cycle, bad_access, is_byte_st;
    logic [7:0] tx, rx, buf_byte;
    logic [31:0] buf_word;

    wire wr_stat = reg_we && reg_addr == AW'(REG_STAT);
    wire wr_ctrl = reg_we && reg_addr == AW'(REG_CTRL) && !busy;
    wire wr_addr = reg_we && reg_addr == AW'(REG_ADDR) && !busy;
    wire wr_buf  = reg_we && reg_addr[AW-1] && !busy;

    assign busy = (r_q.st != ST_IDLE);

    hwseq_req_check #(.CNTW(CNTW), .PAGE_W(PAGE_W)) u_check (
        .typ(reg_wdata[2:1]), .cnt(reg_wdata[8 +: CNTW]),
        .page_off(r_q.addr[PAGE_W-1:0]), .locked(r_q.lock),
        .bad_cycle(bad_cycle), .bad_access(bad_access)
    );

    hwseq_databuf #(.WORDS(BUF_WORDS)) u_buf (
        .clk(clk), .host_we(wr_buf), .host_idx(reg_addr[WIDX-1:0]),
        .host_wdata(reg_wdata), .host_rdata(buf_word),
        .eng_we(bwe), .eng_idx(r_q.idx), .eng_wdata(rx), .eng_rdata(buf_byte)
    );

    hwseq_spi_byte #(.DIV(CLK_DIV)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(start), .tx(tx), .miso(spi_miso),
        .sck(spi_sck), .mosi(spi_mosi), .done(bdone), .rx(rx)
    );

    always_comb begin
        r_d     = r_q;
        start   = 1'b0;
        tx      = 8'h00;
        bwe     = 1'b0;
        fin     = 1'b0;
        set_err = 1'b0;
        set_ael = 1'b0;

        // host side
        if (wr_stat) begin
            r_d.done = r_q.done & ~reg_wdata[0];
            r_d.err  = r_q.err  & ~reg_wdata[1];
            r_d.ael  = r_q.ael  & ~reg_wdata[2];
            r_d.lock = r_q.lock | reg_wdata[15];
        end
        if (wr_addr) r_d.addr = reg_wdata;
        if (wr_ctrl) begin
            r_d.typ = reg_wdata[2:1];
            r_d.cnt = reg_wdata[8 +: CNTW];
            if (reg_wdata[0]) begin
                if (bad_cycle)       set_err = 1'b1;
                else if (bad_access) set_ael = 1'b1;
                else begin
                    r_d.st       = (reg_wdata[2:1] == CT_READ) ? ST_CMD : ST_WREN;
                    r_d.idx      = '0;
                    r_d.launched = 1'b0;
                    r_d.cs_n     = 1'b0;
                end
            end
        end

        // byte launch bookkeeping
        is_byte_st = (r_q.st != ST_IDLE) && (r_q.st != ST_GAP);
        if (is_byte_st && !r_q.launched) begin
            start        = 1'b1;
            r_d.launched = 1'b1;
        end
        if (bdone) r_d.launched = 1'b0;

        // sequencer
        case (r_q.st)
            ST_WREN: begin
                tx = OP_WREN;
                if (bdone) begin
                    r_d.st = ST_GAP; r_d.nxt = ST_CMD; r_d.cs_n = 1'b1; r_d.gap = '0;
                end
            end
            ST_GAP: begin
                if (r_q.gap == GAPW'(GAP_CYC - 1)) begin
                    r_d.st = r_q.nxt; r_d.cs_n = 1'b0; r_d.gap = '0;
                end else begin
                    r_d.gap = r_q.gap + 1'b1;
                end
            end
            ST_CMD: begin
                case (r_q.typ)
                    CT_READ: tx = OP_READ;
                    CT_PROG: tx = OP_PROG;
                    default: tx = OP_ERASE;
                endcase
                if (bdone) begin r_d.st = ST_ADR; r_d.idx = '0; end
            end
            ST_ADR: begin
                case (r_q.idx[1:0])
                    2'd0:    tx = r_q.addr[23:16];
                    2'd1:    tx = r_q.addr[15:8];
                    default: tx = r_q.addr[7:0];
                endcase
                if (bdone) begin
                    if (r_q.idx == CNTW'(2)) begin
                        r_d.idx = '0;
                        if (r_q.typ == CT_ERASE) begin
                            r_d.st = ST_GAP; r_d.nxt = ST_PCMD; r_d.cs_n = 1'b1; r_d.gap = '0;
                        end else begin
                            r_d.st = ST_DAT;
                        end
                    end else begin
                        r_d.idx = r_q.idx + 1'b1;
                    end
                end
            end
            ST_DAT: begin
                tx = (r_q.typ == CT_READ) ? 8'h00 : buf_byte;
                if (bdone) begin
                    bwe = (r_q.typ == CT_READ);
                    if (r_q.idx == r_q.cnt) begin
                        if (r_q.typ == CT_READ) fin = 1'b1;
                        else begin
                            r_d.st = ST_GAP; r_d.nxt = ST_PCMD; r_d.cs_n = 1'b1; r_d.gap = '0;
                        end
                    end else begin
                        r_d.idx = r_q.idx + 1'b1;
                    end
                end
            end
            ST_PCMD: begin
                tx = OP_RDSR;
                if (bdone) r_d.st = ST_PRD;
            end
            ST_PRD: begin
                tx = 8'h00;
                if (bdone && !rx[0]) fin = 1'b1;
            end
            default: ;
        endcase

        // engine-side sets take priority over same-cycle clears
        if (fin) begin
            r_d.st   = ST_IDLE;
            r_d.cs_n = 1'b1;
            r_d.done = 1'b1;
        end
        if (set_err) r_d.err = 1'b1;
        if (set_ael) r_d.ael = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.cs_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign spi_cs_n = r_q.cs_n;

    always_comb begin
        reg_rdata = 32'h0;
        if (reg_addr[AW-1]) begin
            reg_rdata = buf_word;
        end else begin
            case (reg_addr)
                AW'(REG_STAT): reg_rdata = {16'h0, r_q.lock, DESC_VALID, 8'h0, busy,
                                            ERASE_CODE, r_q.ael, r_q.err, r_q.done};
                AW'(REG_CTRL): reg_rdata = {{(24 - CNTW){1'b0}}, r_q.cnt, 5'h0, r_q.typ, 1'b0};
                AW'(REG_ADDR): reg_rdata = r_q.addr;
                default:       reg_rdata = 32'h0;
            endcase
        end
    end
endmodule

// File: rtl/hwseq_flash_engine_chk.sv
`timescale 1ns/1ps
module hwseq_flash_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic sck,
    input logic cs_n,
    input logic busy,
    input logic done,
    input logic err,
    input logic lock
);
    AST_CS_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> cs_n);                          // R9
    AST_SCK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);                           // R2
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> lock);                           // R7
    AST_DONE_WITH_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($rose(cs_n) && !busy));  // R10
    AST_ERR_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> (cs_n && !busy));          // R5
endmodule

bind hwseq_flash_engine hwseq_flash_engine_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sck(spi_sck), .cs_n(spi_cs_n),
    .busy(busy), .done(r_q.done), .err(r_q.err), .lock(r_q.lock)
);

// File: tb/hwseq_flash_engine_test.sv
`timescale 1ns/1ps
module hwseq_flash_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        spi_sck, spi_cs_n, spi_mosi;
    logic        spi_miso = 1'b0;

    hwseq_flash_engine uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(spi_sck),
        .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    always #4 clk = ~clk;

    int total = 0, passed = 0;
    bit finished = 1'b0;

    // ---------------- flash model ----------------
    logic [7:0]  mem [1024];
    logic [7:0]  op_log [64];
    logic [23:0] adr_log [64];
    int          len_log [64];
    int frame_cnt = 0, bitc = 0, bytec = 0, busy_left = 0, fall_cnt = 0;
    logic [7:0]  in_sh = '0, out_sh = '0, out_next = '0, cur_op = '0;
    logic [23:0] cur_adr = '0;

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 7 + 3) & 255);
    endfunction

    initial for (int i = 0; i < 1024; i++) mem[i] = pat(i);

    always @(negedge spi_cs_n) begin bitc = 0; bytec = 0; end

    always @(posedge spi_cs_n) begin
        if (bytec > 0) begin
            len_log[frame_cnt] = bytec;
            if (cur_op == 8'h02) busy_left = 2;
            if (cur_op == 8'hD8) busy_left = 3;
            frame_cnt++;
        end
    end

    always @(posedge spi_sck) begin
        in_sh = {in_sh[6:0], spi_mosi};
        bitc++;
        if (bitc == 8) begin
            bitc = 0;
            if (bytec == 0) begin
                cur_op = in_sh;
                op_log[frame_cnt] = in_sh;
            end else if (bytec <= 3) begin
                cur_adr = {cur_adr[15:0], in_sh};
                if (bytec == 3) begin
                    adr_log[frame_cnt] = cur_adr;
                    if (cur_op == 8'h03) out_next = mem[cur_adr[9:0]];
                end
            end else begin
                if (cur_op == 8'h03) out_next = mem[10'(cur_adr + 24'(bytec - 3))];
                if (cur_op == 8'h02) mem[10'(cur_adr + 24'(bytec - 4))] = in_sh;
            end
            if (cur_op == 8'h05) begin
                out_next = {7'b0, busy_left != 0};
                if (busy_left > 0) busy_left--;
            end
            bytec++;
        end
    end

    always @(negedge spi_sck) begin
        fall_cnt++;
        if (bitc == 0) out_sh = out_next;
        else           out_sh = {out_sh[6:0], 1'b0};
        spi_miso = out_sh[7];
    end

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act === exp) passed++;
        else $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = 5'(a); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        reg_addr = 5'(a);
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 20000; i++) begin
            rd(0, s);
            if (!s[5]) return;
            @(negedge clk);
        end
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        logic [31:0] s;
        rd(0, s);
        chk("R1 status after reset", s & 32'h0000_8027, 32'h0);
        chk("R12 erase code and descriptor valid", s & 32'h0000_4018, 32'h0000_4008);
        chk("R1 chip select idle", {31'b0, spi_cs_n}, 32'h1);
        chk("R1 serial clock idle", {31'b0, spi_sck}, 32'h0);
    endtask

    task automatic t_read();
        logic [31:0] s;
        int f0 = frame_cnt, base;
        wr(2, 32'hFE00_0135);
        rd(2, s);
        chk("R11 address readback", s, 32'hFE00_0135);
        base = fall_cnt;
        wr(1, 32'h0000_0701);
        rd(0, s);
        chk("R9 busy after start", s & 32'h20, 32'h20);
        wait (fall_cnt == base + 8 * (4 + 8));
        @(negedge clk); rd(0, s);
        chk("R10 done not yet at last fall", s & 32'h21, 32'h20);
        @(negedge clk); rd(0, s);
        chk("R10 done one clock later", s & 32'h21, 32'h01);
        chk("R10 chip select high with done", {31'b0, spi_cs_n}, 32'h1);
        chk("R2 one frame", 32'(frame_cnt - f0), 32'd1);
        chk("R2 read opcode", {24'b0, op_log[f0]}, 32'h03);
        chk("R11 low 24 address bits sent", {8'b0, adr_log[f0]}, 32'h000135);
        rd(16, s);
        chk("R2 buffer word 0", s, {pat('h138), pat('h137), pat('h136), pat('h135)});
        rd(17, s);
        chk("R2 buffer word 1", s, {pat('h13c), pat('h13b), pat('h13a), pat('h139)});
    endtask

    task automatic t_go_busy();
        logic [31:0] s;
        int f0 = frame_cnt;
        wr(2, 32'h0000_0040);
        wr(1, 32'h0000_0301);
        wr(1, 32'h0000_0505);
        wr(2, 32'h0000_0055);
        wait_idle();
        chk("R9 second start ignored", 32'(frame_cnt - f0), 32'd1);
        rd(1, s);
        chk("R9 control kept", s, 32'h0000_0300);
        rd(2, s);
        chk("R9 address kept", s, 32'h0000_0040);
        rd(16, s);
        chk("R2 read of 4 bytes", s, {pat('h43), pat('h42), pat('h41), pat('h40)});
    endtask

    task automatic t_cross();
        logic [31:0] s;
        int f0;
        wr(0, 32'h7);
        wr(2, 32'h0000_00F8);
        f0 = frame_cnt;
        wr(1, 32'h0000_0801);
        repeat (4) @(negedge clk);
        rd(0, s);
        chk("R5 crossing read rejected", s & 32'h23, 32'h02);
        wr(1, 32'h0000_0805);
        repeat (4) @(negedge clk);
        chk("R5 no frame on crossing", 32'(frame_cnt - f0), 32'd0);
        wr(0, 32'h2);
        wr(1, 32'h0000_0701);
        wait_idle();
        rd(0, s);
        chk("R5 ending at byte 255 runs", s & 32'h03, 32'h01);
        rd(17, s);
        chk("R5 last page byte read", s[31:24], {24'b0, pat('hFF)});
    endtask

    task automatic t_badtype_w1c();
        logic [31:0] s;
        int f0 = frame_cnt;
        wr(1, 32'h0000_0003);
        repeat (4) @(negedge clk);
        rd(0, s);
        chk("R6 operation 1 sets error", s & 32'h03, 32'h03);
        chk("R6 no frame", 32'(frame_cnt - f0), 32'd0);
        wr(0, 32'h2);
        rd(0, s);
        chk("R8 clear error keeps done", s & 32'h03, 32'h01);
        wr(0, 32'h0);
        rd(0, s);
        chk("R8 writing zero no effect", s & 32'h03, 32'h01);
        wr(0, 32'h1);
    endtask

    task automatic t_prog();
        logic [31:0] s;
        int f0 = frame_cnt;
        wr(16, 32'h4433_2211);
        wr(17, 32'h0000_6655);
        wr(2, 32'h0000_0200);
        wr(1, 32'h0000_0505);
        wait_idle();
        rd(0, s);
        chk("R3 done after program", s & 32'h03, 32'h01);
        chk("R3 three frames", 32'(frame_cnt - f0), 32'd3);
        chk("R3 write enable first", {24'b0, op_log[f0]}, 32'h06);
        chk("R3 program opcode", {24'b0, op_log[f0+1]}, 32'h02);
        chk("R3 program frame length", 32'(len_log[f0+1]), 32'd10);
        chk("R3 poll frame reads until idle", {op_log[f0+2], 24'(len_log[f0+2])}, {8'h05, 24'd4});
        chk("R3 flash bytes", {mem['h203], mem['h202], mem['h201], mem['h200]}, 32'h4433_2211);
        chk("R3 flash bytes tail", {16'b0, mem['h205], mem['h204]}, 32'h0000_6655);
        wr(0, 32'h1);
        wr(16, 32'h0); wr(17, 32'h0);
        wr(1, 32'h0000_0501);
        wait_idle();
        rd(17, s);
        chk("R2 readback of programmed data", s, 32'h0000_6655);
    endtask

    task automatic t_erase();
        logic [31:0] s;
        int f0 = frame_cnt;
        wr(0, 32'h1);
        wr(2, 32'h0000_3000);
        wr(1, 32'h0000_0007);
        wait_idle();
        rd(0, s);
        chk("R4 done after erase", s & 32'h03, 32'h01);
        chk("R4 three frames", 32'(frame_cnt - f0), 32'd3);
        chk("R4 erase opcode and address", {op_log[f0+1], adr_log[f0+1]}, 32'hD800_3000);
        chk("R4 erase frame no data", 32'(len_log[f0+1]), 32'd4);
        chk("R4 poll length", {op_log[f0+2], 24'(len_log[f0+2])}, {8'h05, 24'd5});
    endtask

    task automatic t_collide();
        logic [31:0] s;
        int base;
        wr(1, 32'h0000_0003);
        wr(0, 32'h1);
        rd(0, s);
        chk("R8 setup error only", s & 32'h03, 32'h02);
        wr(2, 32'h0000_0010);
        base = fall_cnt;
        wr(1, 32'h0000_0101);
        wait (fall_cnt == base + 8 * (4 + 2));
        @(negedge clk);
        wr(0, 32'h3);
        rd(0, s);
        chk("R8 set wins over same-cycle clear", s & 32'h23, 32'h01);
    endtask

    task automatic t_lock();
        logic [31:0] s;
        int f0;
        wr(0, 32'h7);
        wr(0, 32'h8000);
        rd(0, s);
        chk("R7 lock set", s & 32'h8000, 32'h8000);
        f0 = frame_cnt;
        wr(2, 32'h0000_0300);
        wr(1, 32'h0000_0005);
        repeat (4) @(negedge clk);
        rd(0, s);
        chk("R7 program refused", s & 32'h07, 32'h04);
        wr(0, 32'h4);
        wr(1, 32'h0000_0007);
        repeat (4) @(negedge clk);
        chk("R7 no frame while locked", 32'(frame_cnt - f0), 32'd0);
        wr(1, 32'h0000_0001);
        wait_idle();
        rd(0, s);
        chk("R7 read still runs", s & 32'h07, 32'h05);
        wr(0, 32'h7);
        rd(0, s);
        chk("R7 lock survives clears", s & 32'h8007, 32'h8000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read();
        t_go_busy();
        t_cross();
        t_badtype_w1c();
        t_prog();
        t_erase();
        t_collide();
        t_lock();
        finished = 1'b1;
        $display("%0d/%0d checks passed", passed, total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", passed, total);
            $finish;
        end
    end
endmodule